// File: doc/BRIEF.md
# Serial Flash Command Gate with Write Protection

This block sits behind the serial port of a flash device and decides which incoming instructions may reach the memory core. It oversamples an SPI mode 0 frame (select low, data on MOSI sampled at rising SCK, most significant bit first) in the system clock domain. It collects the opcode and up to three address bytes. When select rises it issues a verdict on the frame: the frame is executed, refused, or silently dropped.

Program and erase frames that pass every check leave as a one-cycle command pulse to the core, carrying opcode and address. The core answers with a busy level while it works. There is no ready input: back-pressure is expressed only through busy. While a job is in progress the gate forwards nothing new, and the core never sees a second command before its busy level has dropped. Refused modifying frames raise a one-cycle refusal pulse instead.

The gate also holds a status byte. Bit 7 is the status-lock flag, bits 4:2 are the protect level, bit 1 is the write-enable flag and bit 0 is the in-progress flag. Bits 6:5 are zero. It also keeps a low-power sleep state that only one opcode can leave.

Top module: `spiwp_ctrl`

## Requirements
- R1: After reset the write-enable flag, in-progress flag, protect level and status-lock flag are all zero, sleep is low, no command or refusal pulse is raised and MISO is low.
- R2: Opcode 0x05 makes MISO stream the status byte MSB first, starting at the first falling SCK after the opcode and repeating every 8 clocks, laid out as {lock, 0, 0, level[2:0], write-enable, in-progress}.
- R3: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it. Each needs at least 8 bits in the frame. No other opcode sets the flag.
- R4: Opcodes 0x02 (program), 0xD8 (sector erase), 0xC7 (full erase) and 0x01 (status write) are refused with a refusal pulse when the write-enable flag is clear.
- R5: Those four opcodes execute only when the frame's SCK count is a multiple of eight. The frame must also hold at least 5 bytes for 0x02, 4 for 0xD8, 2 for 0x01 and 1 for 0xC7. Any other count is refused.
- R6: An executed status write copies bit 7 and bits 4:2 of its first data byte into the status byte and clears the write-enable flag, without a command pulse.
- R7: A status write is refused while the status-lock flag is 1 and the WP_N pin is low.
- R8: The array has 8 sectors, and the sector is address bits [ADDR_W-1:ADDR_W-3] of the 24-bit address. Level 0 protects nothing, level 1 protects sector 7, level 2 sectors 6..7, level 3 sectors 4..7, and levels 4..7 protect all sectors. A program or sector erase into a protected sector is refused.
- R9: Full erase is refused whenever the protect level is nonzero.
- R10: An executed program or erase raises cmd_vld for one cycle with the opcode and address and sets the in-progress flag. While that flag is set, only 0x05 has any effect. The falling edge of core_busy clears both the in-progress flag and the write-enable flag.
- R11: Opcode 0xB9 in a whole-byte frame enters sleep. In sleep every opcode is dropped and MISO stays low, except 0xAB in a whole-byte frame, which wakes the block.
- R12: When a frame ends in the same cycle that core_busy falls, the frame is judged with the in-progress flag as it stood before that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, MSB first |
| miso | output | 1 | Serial data out, status stream |
| wp_n | input | 1 | Write-protect pin, low locks status writes when the lock flag is set |
| core_busy | input | 1 | Memory core busy level |
| cmd_vld | output | 1 | One-cycle pulse: command forwarded to the core |
| cmd_op | output | 8 | Opcode of the forwarded command |
| cmd_addr | output | ADDR_W | Address of the forwarded command |
| cmd_rej | output | 1 | One-cycle pulse: modifying frame refused |
| sleep | output | 1 | High while in low-power sleep |

## Verification
Two things can happen in the same clock cycle: a frame's closing select edge and the core's busy level dropping. Both change the in-progress flag and whether a frame is allowed to act. The bench provokes the clash by holding busy high behind a forwarded program. It then sends a sleep-entry frame and releases busy on the exact system-clock edge at which the closing select edge has passed the synchronizer. The outcome is judged at the ports: sleep must stay low, because the frame was still dropped as in-progress, and a following status read must show both the in-progress flag and the write-enable flag cleared.

// File: rtl/spiwp_pkg.sv
package spiwp_pkg;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RES  = 8'hAB;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_SE   = 8'hD8;

  localparam int LVL_W  = 3;
  localparam int SECT_W = 3;

  // minimum whole bytes per modifying opcode
  localparam logic [2:0] MIN_PP   = 3'd5;
  localparam logic [2:0] MIN_SE   = 3'd4;
  localparam logic [2:0] MIN_WRSR = 3'd2;

  typedef struct packed {
    logic core_go;
    logic reject;
    logic wel_set;
    logic wel_clr;
    logic sr_write;
    logic pd_enter;
    logic pd_exit;
  } verdict_t;

endpackage

// File: rtl/spiwp_frame.sv
module spiwp_frame #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       frame_start,
  output logic       frame_end,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic [2:0] byte_num,
  output logic [2:0] bit_idx,
  output logic [2:0] byte_cnt
);

  localparam int TOP = SYNC_N - 1;

  logic [SYNC_N-1:0] cs_s, sck_s, mosi_s;
  logic              cs_d, sck_d;
  logic [6:0]        sh_q;
  logic [2:0]        idx_q, cnt_q;
  logic              sck_rise, mosi_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= '1;
      sck_s  <= '0;
      mosi_s <= '0;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_s   <= {cs_s[TOP-1:0], cs_n};
      sck_s  <= {sck_s[TOP-1:0], sck};
      mosi_s <= {mosi_s[TOP-1:0], mosi};
      cs_d   <= cs_s[TOP];
      sck_d  <= sck_s[TOP];
    end
  end

  assign frame_start = ~cs_s[TOP] & cs_d;
  assign frame_end   = cs_s[TOP] & ~cs_d;
  assign sck_rise    = sck_s[TOP] & ~sck_d & ~cs_s[TOP];
  assign mosi_bit    = mosi_s[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (frame_start) begin
      sh_q  <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (sck_rise) begin
      sh_q  <= {sh_q[5:0], mosi_bit};
      idx_q <= idx_q + 3'd1;
      if (idx_q == 3'd7 && cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
    end
  end

  assign byte_stb = sck_rise && (idx_q == 3'd7);
  assign byte_val = {sh_q, mosi_bit};
  assign byte_num = cnt_q;
  assign bit_idx  = idx_q;
  assign byte_cnt = cnt_q;

endmodule

// File: rtl/spiwp_status.sv
module spiwp_status
  import spiwp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wel_set,
  input  logic             wel_clr,
  input  logic             sr_wr,
  input  logic [7:0]       sr_wdata,
  input  logic             wip_set,
  input  logic             core_busy,
  output logic [7:0]       sr,
  output logic             wel,
  output logic             wip,
  output logic [LVL_W-1:0] lvl,
  output logic             lock
);

  logic             wel_q, wip_q, lock_q, busy_d;
  logic [LVL_W-1:0] lvl_q;
  logic             job_done;

  assign job_done = wip_q & busy_d & ~core_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
      lvl_q  <= '0;
      lock_q <= 1'b0;
      busy_d <= 1'b0;
    end else begin
      busy_d <= core_busy;
      if (job_done)     wip_q <= 1'b0;
      else if (wip_set) wip_q <= 1'b1;
      if (job_done || wel_clr) wel_q <= 1'b0;
      else if (wel_set)        wel_q <= 1'b1;
      if (sr_wr) begin
        lvl_q  <= sr_wdata[4:2];
        lock_q <= sr_wdata[7];
      end
    end
  end

  assign sr   = {lock_q, 2'b00, lvl_q, wel_q, wip_q};
  assign wel  = wel_q;
  assign wip  = wip_q;
  assign lvl  = lvl_q;
  assign lock = lock_q;

  // R10
  wip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_q) |-> !wel_q);

  // R3
  wel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(wel_set));

  // R10
  wip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && core_busy) |=> wip_q);

endmodule

// File: rtl/spiwp_guard.sv
module spiwp_guard
  import spiwp_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              have_op,
  input  logic [7:0]        opcode,
  input  logic [2:0]        byte_cnt,
  input  logic              aligned,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wel,
  input  logic              wip,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              lock,
  input  logic              wp_n,
  input  logic              asleep,
  output verdict_t          verdict
);

  localparam logic [SECT_W:0] NSECT = (SECT_W+1)'(1) << SECT_W;
  localparam logic [SECT_W:0] ONE   = (SECT_W+1)'(1);

  logic [SECT_W-1:0] sect;
  logic [SECT_W:0]   nprot;
  logic              in_prot;

  assign sect = addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    if (lvl == '0)                 nprot = '0;
    else if (int'(lvl) > SECT_W)   nprot = NSECT;
    else                           nprot = ONE << (lvl - LVL_W'(1));
    in_prot = (nprot != '0) && ({1'b0, sect} >= (NSECT - nprot));
  end

  always_comb begin
    verdict = '0;
    if (have_op) begin
      if (asleep) begin
        verdict.pd_exit = (opcode == OP_RES) && aligned;
      end else if (!wip) begin
        case (opcode)
          OP_WREN: verdict.wel_set = 1'b1;
          OP_WRDI: verdict.wel_clr = 1'b1;
          OP_WRSR: begin
            if (aligned && byte_cnt >= MIN_WRSR && wel && !(lock && !wp_n))
              verdict.sr_write = 1'b1;
            else
              verdict.reject = 1'b1;
          end
          OP_PP: begin
            if (aligned && byte_cnt >= MIN_PP && wel && !in_prot)
              verdict.core_go = 1'b1;
            else
              verdict.reject = 1'b1;
          end
          OP_SE: begin
            if (aligned && byte_cnt >= MIN_SE && wel && !in_prot)
              verdict.core_go = 1'b1;
            else
              verdict.reject = 1'b1;
          end
          OP_BE: begin
            if (aligned && wel && lvl == '0) verdict.core_go = 1'b1;
            else                             verdict.reject = 1'b1;
          end
          OP_DPD:  verdict.pd_enter = aligned;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spiwp_ctrl.sv
module spiwp_ctrl
  import spiwp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic              wp_n,
  input  logic              core_busy,
  output logic              cmd_vld,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rej,
  output logic              sleep
);

  localparam int WIRE_AW = 24;

  logic             f_start, f_end, b_stb;
  logic [7:0]       b_val;
  logic [2:0]       b_num, bit_idx, b_cnt;
  logic [7:0]       op_q, data_q;
  logic [WIRE_AW-1:0] addr_q;
  logic             have_op_q, rdsr_q, sleep_q;
  logic             vld_q, rej_q;
  logic [7:0]       vop_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [7:0]       st_sr;
  logic             st_wel, st_wip, st_lock;
  logic [LVL_W-1:0] st_lvl;
  verdict_t         v;

  spiwp_frame #(.SYNC_N(SYNC_N)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .frame_start(f_start), .frame_end(f_end), .byte_stb(b_stb),
    .byte_val(b_val), .byte_num(b_num), .bit_idx(bit_idx), .byte_cnt(b_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= '0;
      data_q    <= '0;
      addr_q    <= '0;
      have_op_q <= 1'b0;
      rdsr_q    <= 1'b0;
    end else if (f_start) begin
      have_op_q <= 1'b0;
      rdsr_q    <= 1'b0;
    end else if (f_end) begin
      rdsr_q    <= 1'b0;
    end else if (b_stb) begin
      case (b_num)
        3'd0: begin
          op_q      <= b_val;
          have_op_q <= 1'b1;
          rdsr_q    <= (b_val == OP_RDSR) && !sleep_q;
        end
        3'd1: begin
          addr_q[23:16] <= b_val;
          data_q        <= b_val;
        end
        3'd2: addr_q[15:8] <= b_val;
        3'd3: addr_q[7:0]  <= b_val;
        default: ;
      endcase
    end
  end

  spiwp_guard #(.ADDR_W(ADDR_W)) u_guard (
    .have_op(have_op_q), .opcode(op_q), .byte_cnt(b_cnt),
    .aligned(bit_idx == 3'd0), .addr(addr_q[ADDR_W-1:0]),
    .wel(st_wel), .wip(st_wip), .lvl(st_lvl), .lock(st_lock),
    .wp_n(wp_n), .asleep(sleep_q), .verdict(v)
  );

  spiwp_status u_status (
    .clk(clk), .rst_n(rst_n),
    .wel_set(f_end & v.wel_set),
    .wel_clr(f_end & (v.wel_clr | v.sr_write)),
    .sr_wr(f_end & v.sr_write), .sr_wdata(data_q),
    .wip_set(f_end & v.core_go), .core_busy(core_busy),
    .sr(st_sr), .wel(st_wel), .wip(st_wip), .lvl(st_lvl), .lock(st_lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      vld_q   <= 1'b0;
      rej_q   <= 1'b0;
      vop_q   <= '0;
      vaddr_q <= '0;
    end else begin
      vld_q <= f_end & v.core_go;
      rej_q <= f_end & v.reject;
      if (f_end && v.core_go) begin
        vop_q   <= op_q;
        vaddr_q <= addr_q[ADDR_W-1:0];
      end
      if (f_end && v.pd_enter)     sleep_q <= 1'b1;
      else if (f_end && v.pd_exit) sleep_q <= 1'b0;
    end
  end

  assign miso     = (rdsr_q && !sleep_q) ? st_sr[3'd7 - bit_idx] : 1'b0;
  assign cmd_vld  = vld_q;
  assign cmd_rej  = rej_q;
  assign cmd_op   = vop_q;
  assign cmd_addr = vaddr_q;
  assign sleep    = sleep_q;

  // R4
  fwd_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> $past(st_wel));

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && cmd_rej));

  // R10
  fwd_sets_wip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> st_wip);

  // R7
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sr[7:2] != $past(st_sr[7:2])) |-> ($past(wp_n) || !$past(st_lock)));

  // R11
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> ($past(op_q) == OP_DPD));

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !miso);

  // R11
  sleep_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !(cmd_vld || cmd_rej));

endmodule

// File: tb/test_spiwp_ctrl.sv
module test_spiwp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int ADDR_W = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, core_busy = 1'b0;
  logic miso, cmd_vld, cmd_rej, sleep;
  logic [7:0] cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiwp_ctrl #(.ADDR_W(ADDR_W)) i_spiwp_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .wp_n(wp_n), .core_busy(core_busy), .cmd_vld(cmd_vld),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_rej(cmd_rej), .sleep(sleep)
  );

  int checks = 0, errors = 0;
  int acc_n = 0, rej_n = 0;
  logic [7:0] last_op;
  logic [ADDR_W-1:0] last_addr;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (cmd_vld) begin
      acc_n++;
      last_op = cmd_op;
      last_addr = cmd_addr;
    end
    if (cmd_rej) rej_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_frame(input logic [39:0] bits, input int nbits, input bit drop_busy);
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[39-i];
      sck = 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
    sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    if (drop_busy) begin
      wait_clk(2);
      core_busy = 1'b0;
    end
    wait_clk(8);
  endtask

  task automatic read_sr(output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] got;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 8; i++) begin
      mosi = 1'(8'h05 >> (7 - i));
      sck = 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
    mosi = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sck = 1'b0;
      wait_clk(HALF);
      got[15-i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
    end
    sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
    b0 = got[15:8];
    b1 = got[7:0];
  endtask

  task automatic busy_job();
    @(negedge clk);
    core_busy = 1'b1;
    wait_clk(6);
    core_busy = 1'b0;
    wait_clk(4);
  endtask

  typedef struct packed {
    logic [39:0] bits;
    logic [7:0]  nbits;
    logic [1:0]  res;   // 0 none, 1 forwarded, 2 refused
    logic [7:0]  sr;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{40'h02070000AA, 8'd40, 2'd2, 8'h00}, // R4 program without enable
    '{40'h0600000000, 8'd8,  2'd0, 8'h02}, // R3 enable
    '{40'h0400000000, 8'd8,  2'd0, 8'h00}, // R3 disable
    '{40'h0600000000, 8'd8,  2'd0, 8'h02}, // R3
    '{40'h0200001055, 8'd40, 2'd1, 8'h00}, // R10 program forwarded
    '{40'h0600000000, 8'd8,  2'd0, 8'h02}, // R3
    '{40'hD801000000, 8'd35, 2'd2, 8'h02}, // R5 odd bit count
    '{40'hD803000000, 8'd32, 2'd1, 8'h00}, // R10 sector erase
    '{40'h0600000000, 8'd8,  2'd0, 8'h02}, // R3
    '{40'h010C000000, 8'd16, 2'd0, 8'h0C}, // R6 level 3
    '{40'h0600000000, 8'd8,  2'd0, 8'h0E}, // R3
    '{40'hD804000000, 8'd32, 2'd2, 8'h0E}, // R8 sector 4 locked
    '{40'hD803000000, 8'd32, 2'd1, 8'h0C}, // R8 sector 3 open
    '{40'h0600000000, 8'd8,  2'd0, 8'h0E}, // R3
    '{40'hC700000000, 8'd8,  2'd2, 8'h0E}, // R9 full erase with level
    '{40'h0104000000, 8'd16, 2'd0, 8'h04}, // R6 level 1
    '{40'h0600000000, 8'd8,  2'd0, 8'h06}, // R3
    '{40'hD806000000, 8'd32, 2'd1, 8'h04}, // R8 sector 6 open at level 1
    '{40'h0600000000, 8'd8,  2'd0, 8'h06}, // R3
    '{40'h0207FF0011, 8'd40, 2'd2, 8'h06}, // R8 sector 7 locked
    '{40'h0100000000, 8'd16, 2'd0, 8'h00}, // R6 level 0
    '{40'h0600000000, 8'd8,  2'd0, 8'h02}, // R3
    '{40'hC700000000, 8'd8,  2'd1, 8'h00}, // R9 full erase at level 0
    '{40'h0600000000, 8'd8,  2'd0, 8'h02}, // R3
    '{40'h0100000000, 8'd15, 2'd2, 8'h02}, // R5 short status write
    '{40'h0110000000, 8'd16, 2'd0, 8'h10}, // R6 level 4
    '{40'h0600000000, 8'd8,  2'd0, 8'h12}, // R3
    '{40'h0200000011, 8'd40, 2'd2, 8'h12}, // R8 level 4 locks sector 0
    '{40'h019C000000, 8'd16, 2'd0, 8'h9C}, // R6 lock flag and level 7
    '{40'h0600000000, 8'd8,  2'd0, 8'h9E}  // R3
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s0, s1;
    int a0, r0, got;

    wait_clk(5);
    // R1 reset state at the pins
    chk(!miso && !cmd_vld && !cmd_rej && !sleep, "R1 pins in reset", {miso, cmd_vld, cmd_rej, sleep}, 0);
    rst_n = 1'b1;
    wait_clk(4);
    read_sr(s0, s1);
    chk(s0 == 8'h00, "R1 status after reset", s0, 8'h00);

    for (int k = 0; k < NV; k++) begin
      a0 = acc_n;
      r0 = rej_n;
      spi_frame(VECS[k].bits, int'(VECS[k].nbits), 1'b0);
      got = (acc_n > a0) ? 1 : (rej_n > r0) ? 2 : 0;
      chk(got == int'(VECS[k].res), $sformatf("R%0d-table verdict vector %0d", 4, k), got, VECS[k].res);
      if (got == 1) begin
        // R10 forwarded opcode and address
        chk(last_op == VECS[k].bits[39:32], "R10 forwarded opcode", last_op, VECS[k].bits[39:32]);
        if (last_op != 8'hC7)
          chk(last_addr == VECS[k].bits[ADDR_W+7:8], "R10 forwarded address", last_addr, VECS[k].bits[ADDR_W+7:8]);
        busy_job();
      end
      read_sr(s0, s1);
      chk(s0 == VECS[k].sr, $sformatf("R2 status after vector %0d", k), s0, VECS[k].sr);
    end

    // R7 lock flag set and pin low refuses status write
    wp_n = 1'b0;
    r0 = rej_n;
    spi_frame(40'h0100000000, 16, 1'b0);
    chk(rej_n == r0 + 1, "R7 refused under pin lock", rej_n - r0, 1);
    read_sr(s0, s1);
    chk(s0 == 8'h9E, "R7 status untouched", s0, 8'h9E);
    wp_n = 1'b1;
    spi_frame(40'h0100000000, 16, 1'b0);
    read_sr(s0, s1);
    chk(s0 == 8'h00, "R7 pin high allows write", s0, 8'h00);

    // R10 in-progress window
    spi_frame(40'h0600000000, 8, 1'b0);
    a0 = acc_n;
    spi_frame(40'h0200010033, 40, 1'b0);
    chk(acc_n == a0 + 1, "R10 program forwarded", acc_n - a0, 1);
    @(negedge clk);
    core_busy = 1'b1;
    read_sr(s0, s1);
    chk(s0 == 8'h03, "R10 status while busy", s0, 8'h03);
    chk(s1 == s0, "R2 status stream repeats", s1, s0);
    spi_frame(40'h0400000000, 8, 1'b0);
    a0 = acc_n; r0 = rej_n;
    spi_frame(40'h0200010033, 40, 1'b0);
    chk(acc_n == a0 && rej_n == r0, "R10 program dropped while busy", acc_n - a0 + rej_n - r0, 0);
    read_sr(s0, s1);
    chk(s0 == 8'h03, "R10 disable dropped while busy", s0, 8'h03);

    // R12 sleep entry frame ends on the busy fall
    spi_frame(40'hB900000000, 8, 1'b1);
    chk(!sleep, "R12 frame judged as in-progress", sleep, 0);
    read_sr(s0, s1);
    chk(s0 == 8'h00, "R12 flags cleared by busy fall", s0, 8'h00);

    // R11 sleep
    spi_frame(40'h0600000000, 8, 1'b0);
    spi_frame(40'hB900000000, 9, 1'b0);
    chk(!sleep, "R11 misaligned entry ignored", sleep, 0);
    spi_frame(40'hB900000000, 8, 1'b0);
    chk(sleep, "R11 entry", sleep, 1);
    read_sr(s0, s1);
    chk(s0 == 8'h00, "R11 status read silent in sleep", s0, 8'h00);
    spi_frame(40'h0400000000, 8, 1'b0);
    spi_frame(40'hAB00000000, 12, 1'b0);
    chk(sleep, "R11 misaligned release ignored", sleep, 1);
    spi_frame(40'hAB00000000, 8, 1'b0);
    chk(!sleep, "R11 release", sleep, 0);
    read_sr(s0, s1);
    chk(s0 == 8'h02, "R11 disable ignored in sleep", s0, 8'h02);

    // R2 reserved bits read zero
    spi_frame(40'h01FF000000, 16, 1'b0);
    read_sr(s0, s1);
    chk(s0 == 8'h9C, "R2 reserved bits zero", s0, 8'h9C);

    // R1 reset mid-run
    spi_frame(40'h0600000000, 8, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    read_sr(s0, s1);
    chk(s0 == 8'h00, "R1 reset clears status", s0, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule